// File: doc/BRIEF.md
# Remote Miss Fraction Hysteresis Controller

This block decides whether a cache replacement policy should favour keeping lines fetched from another socket's memory. It watches a stream of cache miss events, each tagged local or remote. It counts both kinds over back-to-back windows of a fixed number of clock cycles. At the close of each window it compares the share of remote misses against two thresholds. The upper threshold switches the bias on and the lower one switches it off, so the output does not toggle while the ratio sits between them.

Both thresholds are rational numbers given as numerator/denominator parameters. The ratio test is done by cross-multiplying small integers, so no divider is needed. The counts of the window that just closed are held on outputs for observation until the next window closes.

Top module: `rmf_bias_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `bias_en` is 0 and both `last_total` and `last_remote` are 0 until the first window closes.
- R2: A window closes on every WIN_LEN-th clock cycle after reset release. When it closes, `last_total` and `last_remote` take the number of misses and remote misses counted in that window. They hold that value until the next close.
- R3: A cycle counts as a remote miss only when `miss_vld` and `miss_remote` are both 1. `miss_remote` with `miss_vld` at 0 changes no count.
- R4: At a close with a nonzero total, `bias_en` becomes 1 when remote*HI_DEN > total*HI_NUM. Equality does not turn it on.
- R5: At a close with a nonzero total, `bias_en` becomes 0 when remote*LO_DEN < total*LO_NUM. Equality does not turn it off.
- R6: At a close where neither R4 nor R5 applies, `bias_en` keeps its value.
- R7: A window with zero total misses leaves `bias_en` unchanged.
- R8: A miss presented in the cycle in which a window closes is not part of the closing window. It is the first event of the next window.
- R9: Both counters saturate at 2^CNT_W-1 and never wrap.
- R10: `bias_en` changes only on the clock edge that ends a window-closing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | One cache miss in this cycle |
| miss_remote | input | 1 | The miss in this cycle came from remote memory |
| bias_en | output | 1 | Remote-line bias enable, with hysteresis |
| last_total | output | CNT_W | Total misses of the most recently closed window |
| last_remote | output | CNT_W | Remote misses of the most recently closed window |

## Verification
The properties assume that the threshold parameters are sane: the upper fraction is above the lower one, so the switch-on and switch-off conditions never hold in the same window. The bench keeps the defaults of 1/2 and 1/10. The properties also treat `miss_remote` as meaningless without `miss_vld`. The stimulus therefore raises `miss_remote` alone in one window to show that nothing is counted. Window stimulus is aligned to the close cycle, and misses are placed in that cycle only where R8 is under test. Per-window counts stay within the 4-bit counters of the bench, except in the window that tests saturation.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_SET  = 2'd1,
        DEC_CLR  = 2'd2
    } bias_dec_e;
endpackage

// File: rtl/rmf_win_timer.sv
module rmf_win_timer #(
    parameter int unsigned WIN_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int unsigned TW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

    logic [TW-1:0] tick_d, tick_q;

    assign win_end = (tick_q == LAST);

    always_comb begin
        tick_d = win_end ? '0 : tick_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end
endmodule

// File: rtl/rmf_sat_cnt.sv
module rmf_sat_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] val_d, val_q;

    always_comb begin
        if (restart)                  val_d = {{(W-1){1'b0}}, inc};
        else if (inc && val_q != TOP) val_d = val_q + 1'b1;
        else                          val_d = val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/rmf_hyst_decide.sv
module rmf_hyst_decide
    import rmf_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned HI_NUM = 1,
    parameter int unsigned HI_DEN = 2,
    parameter int unsigned LO_NUM = 1,
    parameter int unsigned LO_DEN = 10
) (
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] remote,
    output bias_dec_e        dec
);
    localparam int unsigned KMAX = (HI_NUM > HI_DEN ? HI_NUM : HI_DEN) >
                                   (LO_NUM > LO_DEN ? LO_NUM : LO_DEN) ?
                                   (HI_NUM > HI_DEN ? HI_NUM : HI_DEN) :
                                   (LO_NUM > LO_DEN ? LO_NUM : LO_DEN);
    localparam int unsigned KW = $clog2(KMAX + 1);
    localparam int unsigned PW = CNT_W + KW;

    localparam logic [PW-1:0] K_HN = PW'(HI_NUM);
    localparam logic [PW-1:0] K_HD = PW'(HI_DEN);
    localparam logic [PW-1:0] K_LN = PW'(LO_NUM);
    localparam logic [PW-1:0] K_LD = PW'(LO_DEN);

    logic [PW-1:0] tot_w, rem_w;
    logic          above_hi, below_lo;

    always_comb begin
        tot_w    = PW'(total);
        rem_w    = PW'(remote);
        above_hi = (rem_w * K_HD) > (tot_w * K_HN);
        below_lo = (rem_w * K_LD) < (tot_w * K_LN);
        if (total == '0)   dec = DEC_HOLD;
        else if (above_hi) dec = DEC_SET;
        else if (below_lo) dec = DEC_CLR;
        else               dec = DEC_HOLD;
    end
endmodule

// File: rtl/rmf_bias_ctrl.sv
module rmf_bias_ctrl
    import rmf_pkg::*;
#(
    parameter int unsigned WIN_LEN = 256,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned HI_NUM  = 1,
    parameter int unsigned HI_DEN  = 2,
    parameter int unsigned LO_NUM  = 1,
    parameter int unsigned LO_DEN  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_vld,
    input  logic             miss_remote,
    output logic             bias_en,
    output logic [CNT_W-1:0] last_total,
    output logic [CNT_W-1:0] last_remote
);
    localparam int unsigned NCNT = 2;

    typedef struct packed {
        logic             bias;
        logic [CNT_W-1:0] tot;
        logic [CNT_W-1:0] rem;
    } ctl_state_t;

    logic             win_end;
    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_val [NCNT];
    logic [CNT_W-1:0] tot_cnt, rem_cnt;
    bias_dec_e        dec;
    ctl_state_t       st_d, st_q;

    rmf_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    assign cnt_inc[0] = miss_vld;
    assign cnt_inc[1] = miss_vld & miss_remote;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rmf_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (win_end),
            .inc     (cnt_inc[g]),
            .value   (cnt_val[g])
        );
    end

    assign tot_cnt = cnt_val[0];
    assign rem_cnt = cnt_val[1];

    rmf_hyst_decide #(
        .CNT_W(CNT_W), .HI_NUM(HI_NUM), .HI_DEN(HI_DEN),
        .LO_NUM(LO_NUM), .LO_DEN(LO_DEN)
    ) u_decide (
        .total  (tot_cnt),
        .remote (rem_cnt),
        .dec    (dec)
    );

    always_comb begin
        st_d = st_q;
        if (win_end) begin
            st_d.tot = tot_cnt;
            st_d.rem = rem_cnt;
            case (dec)
                DEC_SET: st_d.bias = 1'b1;
                DEC_CLR: st_d.bias = 1'b0;
                default: st_d.bias = st_q.bias;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bias_en     = st_q.bias;
    assign last_total  = st_q.tot;
    assign last_remote = st_q.rem;
endmodule

// File: rtl/rmf_bias_ctrl_chk.sv
module rmf_bias_ctrl_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned HI_NUM = 1,
    parameter int unsigned HI_DEN = 2,
    parameter int unsigned LO_NUM = 1,
    parameter int unsigned LO_DEN = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_vld,
    input logic             win_end,
    input logic [CNT_W-1:0] tot_cnt,
    input logic [CNT_W-1:0] rem_cnt,
    input logic             bias_en,
    input logic [CNT_W-1:0] last_total,
    input logic [CNT_W-1:0] last_remote
);
    logic hi_hit, lo_hit;
    assign hi_hit = (64'(rem_cnt) * 64'(HI_DEN)) > (64'(tot_cnt) * 64'(HI_NUM));
    assign lo_hit = (64'(rem_cnt) * 64'(LO_DEN)) < (64'(tot_cnt) * 64'(LO_NUM));

    a_r10_bias_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(bias_en));

    a_r2_counts_held: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(last_total) && $stable(last_remote)));

    a_r3_remote_within_total: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_cnt <= tot_cnt) && (last_remote <= last_total));

    a_r4_switch_on: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && tot_cnt != '0 && hi_hit) |=> bias_en);

    a_r5_switch_off: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && tot_cnt != '0 && lo_hit) |=> !bias_en);

    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !hi_hit && !lo_hit) |=> $stable(bias_en));

    a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && tot_cnt == '0) |=> $stable(bias_en));

    a_r8_close_miss_carried: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (tot_cnt == CNT_W'($past(miss_vld))));

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && tot_cnt == {CNT_W{1'b1}}) |=> (tot_cnt == {CNT_W{1'b1}}));
endmodule

bind rmf_bias_ctrl rmf_bias_ctrl_chk #(
    .CNT_W(CNT_W), .HI_NUM(HI_NUM), .HI_DEN(HI_DEN),
    .LO_NUM(LO_NUM), .LO_DEN(LO_DEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_vld    (miss_vld),
    .win_end     (win_end),
    .tot_cnt     (tot_cnt),
    .rem_cnt     (rem_cnt),
    .bias_en     (bias_en),
    .last_total  (last_total),
    .last_remote (last_remote)
);

// File: tb/rmf_bias_ctrl_bench.sv
`timescale 1ns/1ps
module rmf_bias_ctrl_bench;
    localparam int WIN = 16;
    localparam int CW  = 4;

    typedef struct packed {
        logic [7:0] nt;
        logic [7:0] nr;
        logic       eb;
        logic [7:0] et;
        logic [7:0] er;
    } vec_t;

    // per window: misses, remote misses, expected bias, expected counts
    // thresholds 1/2 (R4) and 1/10 (R5)
    localparam vec_t TBL [0:8] = '{
        '{8'd10, 8'd5,  1'b0, 8'd10, 8'd5 },  // R4 equality -> R6 hold off
        '{8'd10, 8'd6,  1'b1, 8'd10, 8'd6 },  // R4 on
        '{8'd10, 8'd2,  1'b1, 8'd10, 8'd2 },  // R6 hold on
        '{8'd10, 8'd1,  1'b1, 8'd10, 8'd1 },  // R5 equality -> hold
        '{8'd0,  8'd0,  1'b1, 8'd0,  8'd0 },  // R7 empty window
        '{8'd12, 8'd1,  1'b0, 8'd12, 8'd1 },  // R5 off
        '{8'd8,  8'd4,  1'b0, 8'd8,  8'd4 },  // R4 equality, stays off
        '{8'd15, 8'd15, 1'b1, 8'd15, 8'd15},  // R4 on, all remote
        '{8'd11, 8'd0,  1'b0, 8'd11, 8'd0 }   // R5 off, no remote
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_vld = 1'b0;
    logic miss_remote = 1'b0;
    logic bias_en;
    logic [CW-1:0] last_total, last_remote;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rmf_bias_ctrl #(.WIN_LEN(WIN), .CNT_W(CW)) u_rmf_bias_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_vld    (miss_vld),
        .miss_remote (miss_remote),
        .bias_en     (bias_en),
        .last_total  (last_total),
        .last_remote (last_remote)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one window; misses in the first nt non-close cycles,
    // stray=1 raises miss_remote only in cycles without a miss
    task automatic run_window(input int nt, input int nr, input bit stray,
                              input bit bm, input bit br);
        logic b0;
        b0 = bias_en;
        for (int i = 0; i < WIN - 1; i++) begin
            miss_vld    = (i < nt);
            miss_remote = stray ? !(i < nt) : (i < nr);
            @(negedge clk);
            if (i == WIN / 2) chk("R10 mid-window bias", int'(bias_en), int'(b0));
        end
        miss_vld    = bm;
        miss_remote = br;
        @(negedge clk);
        miss_vld    = 1'b0;
        miss_remote = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 bias in reset", int'(bias_en), 0);
        chk("R1 total in reset", int'(last_total), 0);
        chk("R1 remote in reset", int'(last_remote), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bias after release", int'(bias_en), 0);
        // restart from reset so window alignment is exact
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        foreach (TBL[k]) begin
            run_window(int'(TBL[k].nt), int'(TBL[k].nr), 1'b0, 1'b0, 1'b0);
            chk("R2 last_total", int'(last_total), int'(TBL[k].et));
            chk("R2 last_remote", int'(last_remote), int'(TBL[k].er));
            chk("R4/R5/R6/R7 bias", int'(bias_en), int'(TBL[k].eb));
        end

        // R3: remote flag without a miss is ignored
        run_window(4, 0, 1'b1, 1'b0, 1'b0);
        chk("R3 total", int'(last_total), 4);
        chk("R3 remote ignored", int'(last_remote), 0);
        chk("R3 bias", int'(bias_en), 0);

        // R8: a remote miss in the close cycle belongs to the next window
        run_window(10, 10, 1'b0, 1'b1, 1'b1);
        chk("R8 total excludes close miss", int'(last_total), 10);
        chk("R8 remote excludes close miss", int'(last_remote), 10);
        chk("R4 bias on", int'(bias_en), 1);

        // R9: 1 carried + 15 = 16 saturates at 15; R8 remote carried in
        run_window(15, 0, 1'b0, 1'b0, 1'b0);
        chk("R9 total saturates", int'(last_total), 15);
        chk("R8 carried remote", int'(last_remote), 1);
        chk("R5 bias off", int'(bias_en), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule